// File: doc/BRIEF.md
# Static-Latency Counter Sequencer

This block sequences a fixed schedule of hardware groups whose latencies are known when the design is built. A single start pulse begins a run, and one step counter then advances on every clock. Each group's activation output is decoded from that counter. It is high for a window whose length is the group's declared latency, and the window begins on the cycle after the previous group's window ends. No completion handshake is received from any group. Completion is inferred from the declared latencies alone.

When the last window has passed, the block raises a one-cycle completion pulse. It then returns to idle with the counter cleared and waits for the next start. The per-group latencies are a parameter array, so the same block serves any schedule length or shape. Window bounds are running sums of that array and are computed at elaboration.

Top module: `static_seqr`

## Requirements
- R1: While `rst_ni` is low, every group activation and `done_o` are low, regardless of `go_i`, and the block is idle once reset is released; reset may arrive mid-run and aborts the run.
- R2: When `go_i` is high at a clock edge while the block is idle, group 0's activation is high during the cycle that follows that edge (step count 0).
- R3: During a run, the step count advances by exactly one every clock cycle; no input other than reset alters the pace.
- R4: Group k is active exactly for the step counts from S(k) to S(k)+LAT[k]-1, where S(k) is the sum of the latencies of groups 0..k-1; with the default latencies (1,2,2), group 0 is active at count 0, group 1 at counts 1-2, and group 2 at counts 3-4.
- R5: The windows are contiguous: group k+1 turns on in the cycle immediately after group k turns off.
- R6: At most one of the group activations and `done_o` is high in any cycle.
- R7: `done_o` is high for exactly one cycle, at step count equal to the total latency, which is the cycle right after the last group's window; no group is active in that cycle.
- R8: In the cycle after `done_o`, all outputs are low and the block is idle; a `go_i` high at the edge that ends that cycle starts a new run.
- R9: `go_i` is ignored while a run is in progress, including the `done_o` cycle: it neither restarts nor extends the run.
- R10: While idle with `go_i` low, all group activations and `done_o` stay low.
- R11: The schedule follows the latency parameter for any group count; with four groups of latencies (3,1,4,2) the windows are counts 0-2, 3, 4-7, 8-9 and `done_o` comes at count 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| go_i | input | 1 | Start request, sampled only while idle |
| grp_go_o | output | NUM_GROUPS | Activation for each group; bit k drives group k |
| done_o | output | 1 | One-cycle completion pulse at the end of the schedule |

## Verification
Every output comes from registered state, so a start sampled at an edge shows up as group 0's activation during the very next cycle. Group k is then due S(k) cycles later, and the completion pulse is due TOTAL cycles after the first activation. A reset takes effect in the same cycle because it is asynchronous. The driver applies inputs just after each rising edge and pushes the outputs it expects for that same cycle. The monitor compares them at the falling edge, so each expectation is checked in the cycle it predicts and never a cycle early or late. Two instances run in lockstep under identical stimulus, one with the default schedule and one with a four-group schedule.

// File: rtl/static_seqr_pkg.sv
package static_seqr_pkg;

    // Run phase of the step counter.
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    // Bits needed to hold every count from 0 up to top_value inclusive.
    function automatic int unsigned count_bits(input int unsigned top_value);
        return (top_value < 1) ? 1 : $clog2(top_value + 1);
    endfunction

endpackage

// File: rtl/static_seqr_step.sv
module static_seqr_step
    import static_seqr_pkg::*;
#(
    parameter int unsigned TOTAL = 5,
    parameter int unsigned CW    = 3
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          go_i,
    output logic          running_o,
    output logic [CW-1:0] count_o
);

    localparam logic [CW-1:0] LAST = CW'(TOTAL);

    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] count;
    } step_t;

    step_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (st_q.phase)
            PH_IDLE: begin
                st_d.count = '0;
                if (go_i) begin
                    st_d.phase = PH_RUN;
                end
            end
            PH_RUN: begin
                if (st_q.count == LAST) begin
                    st_d.phase = PH_IDLE;
                    st_d.count = '0;
                end else begin
                    st_d.count = st_q.count + 1'b1;
                end
            end
            default: st_d = '{phase: PH_IDLE, count: '0};
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{phase: PH_IDLE, count: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign running_o = (st_q.phase == PH_RUN);
    assign count_o   = st_q.count;

endmodule

// File: rtl/static_seqr_win.sv
module static_seqr_win #(
    parameter int unsigned CW = 3,
    parameter int unsigned LO = 0,
    parameter int unsigned HI = 0
) (
    input  logic          running_i,
    input  logic [CW-1:0] count_i,
    output logic          hit_o
);

    localparam logic [CW-1:0] LO_C = CW'(LO);
    localparam logic [CW-1:0] HI_C = CW'(HI);

    generate
        if (LO == HI) begin : g_point
            assign hit_o = running_i && (count_i == LO_C);
        end else if (LO == 0) begin : g_head
            assign hit_o = running_i && (count_i <= HI_C);
        end else begin : g_span
            assign hit_o = running_i && (count_i >= LO_C) && (count_i <= HI_C);
        end
    endgenerate

endmodule

// File: rtl/static_seqr.sv
module static_seqr
    import static_seqr_pkg::*;
#(
    parameter int unsigned NUM_GROUPS      = 3,
    parameter int unsigned LAT[NUM_GROUPS] = '{1, 2, 2}
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  go_i,
    output logic [NUM_GROUPS-1:0] grp_go_o,
    output logic                  done_o
);

    // First step count of group idx: sum of all earlier latencies.
    function automatic int unsigned win_lo(input int unsigned idx);
        int unsigned acc = 0;
        for (int unsigned i = 0; i < idx; i++) begin
            acc += LAT[i];
        end
        return acc;
    endfunction

    localparam int unsigned TOTAL = win_lo(NUM_GROUPS);
    localparam int unsigned CW    = count_bits(TOTAL);

    logic          run_w;
    logic [CW-1:0] cnt_w;

    static_seqr_step #(
        .TOTAL (TOTAL),
        .CW    (CW)
    ) step_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .go_i      (go_i),
        .running_o (run_w),
        .count_o   (cnt_w)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_GROUPS; g++) begin : g_grp
            localparam int unsigned W_LO = win_lo(g);
            static_seqr_win #(
                .CW (CW),
                .LO (W_LO),
                .HI (W_LO + LAT[g] - 1)
            ) win_i (
                .running_i (run_w),
                .count_i   (cnt_w),
                .hit_o     (grp_go_o[g])
            );
        end
    endgenerate

    static_seqr_win #(
        .CW (CW),
        .LO (TOTAL),
        .HI (TOTAL)
    ) fin_i (
        .running_i (run_w),
        .count_i   (cnt_w),
        .hit_o     (done_o)
    );

endmodule

// File: rtl/static_seqr_chk.sv
module static_seqr_chk #(
    parameter int unsigned NUM_GROUPS      = 3,
    parameter int unsigned LAT[NUM_GROUPS] = '{1, 2, 2}
) (
    input logic                  clk_i,
    input logic                  rst_ni,
    input logic                  go_i,
    input logic [NUM_GROUPS-1:0] grp_go_i,
    input logic                  done_i,
    input logic                  busy_i
);

    // Length of the current high stretch of each activation.
    logic [15:0] len_q [NUM_GROUPS];

    genvar g;
    generate
        for (g = 0; g < NUM_GROUPS; g++) begin : g_len
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    len_q[g] <= '0;
                end else if (grp_go_i[g]) begin
                    len_q[g] <= len_q[g] + 16'd1;
                end else begin
                    len_q[g] <= '0;
                end
            end

            AST_WIN_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
                $fell(grp_go_i[g]) |-> (len_q[g] == 16'(LAT[g]))); // R4

            if (g + 1 < NUM_GROUPS) begin : g_next
                AST_HANDOFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
                    $fell(grp_go_i[g]) |-> grp_go_i[g+1]); // R5
            end else begin : g_last
                AST_LAST_TO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
                    $fell(grp_go_i[g]) |-> done_i); // R7
            end
        end
    endgenerate

    AST_LAUNCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_i && go_i) |=> grp_go_i[0]); // R2

    AST_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({grp_go_i, done_i})); // R6

    AST_DONE_THEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i |=> (!busy_i && !done_i && (grp_go_i == '0))); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_i |-> (!done_i && (grp_go_i == '0))); // R10

    AST_RUN_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_i && !done_i) |=> busy_i); // R9

endmodule

bind static_seqr static_seqr_chk #(
    .NUM_GROUPS (NUM_GROUPS),
    .LAT        (LAT)
) chk_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .go_i     (go_i),
    .grp_go_i (grp_go_o),
    .done_i   (done_o),
    .busy_i   (run_w)
);

// File: tb/static_seqr_tb_top.sv
module static_seqr_tb_top;

    localparam int NA = 3;
    localparam int NB = 4;
    localparam int unsigned LAT_A[NA] = '{1, 2, 2};
    localparam int unsigned LAT_B[NB] = '{3, 1, 4, 2};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic go = 1'b0;
    logic [NA-1:0] grp_a;
    logic [NB-1:0] grp_b;
    logic done_a, done_b;

    always #2.5 clk = ~clk;   // 200 MHz

    static_seqr #(.NUM_GROUPS(NA), .LAT(LAT_A)) dut_i (
        .clk_i (clk), .rst_ni (rst_n), .go_i (go),
        .grp_go_o (grp_a), .done_o (done_a)
    );

    static_seqr #(.NUM_GROUPS(NB), .LAT(LAT_B)) dut_b_i (
        .clk_i (clk), .rst_ni (rst_n), .go_i (go),
        .grp_go_o (grp_b), .done_o (done_b)
    );

    typedef struct {
        logic [3:0] ga;
        logic       da;
        logic [3:0] gb;
        logic       db;
        string      tag;
    } item_t;

    item_t exp_q[$];
    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    // Reference schedule state, derived from the requirements.
    bit ra_busy = 0, rb_busy = 0;
    int ra_cnt = 0, rb_cnt = 0;

    function automatic int total_of(input int n, input int lat[4]);
        int s = 0;
        for (int i = 0; i < n; i++) s += lat[i];
        return s;
    endfunction

    function automatic logic [3:0] exp_grp(input bit busy, input int cnt,
                                           input int n, input int lat[4]);
        logic [3:0] r = '0;
        int lo = 0;
        if (!busy) return r;
        for (int i = 0; i < n; i++) begin
            if (cnt >= lo && cnt < lo + lat[i]) r[i] = 1'b1;
            lo += lat[i];
        end
        return r;
    endfunction

    int la[4] = '{1, 2, 2, 0};
    int lb[4] = '{3, 1, 4, 2};

    task automatic step(input logic r, input logic g, input string tag);
        item_t it;
        int ta, tb;
        @(posedge clk);
        #1;
        rst_n = r;
        go    = g;
        ta = total_of(NA, la);
        tb = total_of(NB, lb);
        // Outputs expected during this cycle (reset is asynchronous).
        it.ga = r ? exp_grp(ra_busy, ra_cnt, NA, la) : 4'b0;
        it.gb = r ? exp_grp(rb_busy, rb_cnt, NB, lb) : 4'b0;
        it.da = r && ra_busy && (ra_cnt == ta);
        it.db = r && rb_busy && (rb_cnt == tb);
        it.tag = it.da ? "R7" : tag;
        exp_q.push_back(it);
        // State after the next rising edge.
        if (!r) begin
            ra_busy = 0; ra_cnt = 0; rb_busy = 0; rb_cnt = 0;
        end else begin
            if (ra_busy) begin
                if (ra_cnt == ta) begin ra_busy = 0; ra_cnt = 0; end
                else ra_cnt++;
            end else if (g) begin ra_busy = 1; ra_cnt = 0; end
            if (rb_busy) begin
                if (rb_cnt == tb) begin rb_busy = 0; rb_cnt = 0; end
                else rb_cnt++;
            end else if (g) begin rb_busy = 1; rb_cnt = 0; end
        end
    endtask

    // Monitor: compares each cycle's outputs at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                vectors++;
                if ({1'b0, grp_a} !== it.ga || done_a !== it.da) begin
                    miscompares++;
                    $display("FAIL %s: default schedule grp=%b done=%b, expected grp=%b done=%b",
                             it.tag, grp_a, done_a, it.ga[NA-1:0], it.da);
                end
                vectors++;
                if (grp_b !== it.gb || done_b !== it.db) begin
                    miscompares++;
                    $display("FAIL R11 (%s): four-group schedule grp=%b done=%b, expected grp=%b done=%b",
                             it.tag, grp_b, done_b, it.gb, it.db);
                end
                vectors++;
                if ($countones({grp_a, done_a}) > 1) begin
                    miscompares++;
                    $display("FAIL R6: active outputs=%0d, expected at most 1",
                             $countones({grp_a, done_a}));
                end
            end
        end
    end

    // Driver: scenario stimulus.
    initial begin
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, "R1");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, "R10");
        // Single launch and full run.
        step(1'b1, 1'b1, "R2");
        for (int i = 0; i < 12; i++) step(1'b1, 1'b0, "R3/R4/R5");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, "R8");
        // Start held high: restarts only from idle.
        for (int i = 0; i < 30; i++) step(1'b1, 1'b1, "R9");
        for (int i = 0; i < 14; i++) step(1'b1, 1'b0, "R8");
        // Start pulses in mid run are ignored.
        step(1'b1, 1'b1, "R2");
        step(1'b1, 1'b0, "R4");
        step(1'b1, 1'b0, "R4");
        step(1'b1, 1'b1, "R9");
        step(1'b1, 1'b1, "R9");
        for (int i = 0; i < 10; i++) step(1'b1, 1'b0, "R9");
        // Reset in mid run.
        step(1'b1, 1'b1, "R2");
        step(1'b1, 1'b0, "R4");
        step(1'b1, 1'b0, "R4");
        step(1'b0, 1'b0, "R1");
        step(1'b0, 1'b1, "R1");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, "R1");
        // Final run.
        step(1'b1, 1'b1, "R2");
        for (int i = 0; i < 13; i++) step(1'b1, 1'b0, "R4");
        @(posedge clk);
        @(negedge clk);
        @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1'b1;
            miscompares++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule